// File: doc/BRIEF.md
# Watermark-Throttled UART Receiver

This block turns an asynchronous serial input line into bytes held in an on-chip receive queue. The character format (five to eight data bits, one of five parity modes, one, one-and-a-half or two stop bits) and the bit period in clock cycles come in on static configuration inputs, and the same settings serve the companion transmitter elsewhere in the chip. Each received character is stored together with its parity and framing status, and a byte-wide read port with a pop strobe drains the queue in arrival order.

The block paces the remote sender through an active-low request-to-send output. The output goes high once the queue holds a fixed high-water number of entries, which is below the full depth, so the far end has room for characters already in flight. A lamp output stays high while the line is quiet and blinks at a slow, parameter-set rate while a character is being assembled. A flush input empties the queue and clears the sticky overrun flag. The flush is the action taken whenever the serial port is opened.

Top module: `serial_rx_wm`

## Requirements
- R1: After reset, `rdValid` is 0, `rtsN` is 0, `overrun` is 0 and `ledOut` is 1.
- R2: `cfgDataBits` selects the character length as 5 + code (0 = 5 bits ... 3 = 8 bits). Data bits arrive least significant first, and `rdData` carries them zero-extended to 8 bits.
- R3: `cfgParity` code 0 means no parity bit, 1 even, 2 odd, 3 mark (bit always 1), 4 space (bit always 0). A received parity bit that differs from the expected value sets `rdParErr` for that entry. With no parity, `rdParErr` is 0.
- R4: `cfgStop` code 0 means one stop bit, 1 one and a half, 2 two. The first stop bit is always checked, and with code 2 the second stop bit is checked too. A low sample in a checked stop bit sets `rdFrameErr`, and the character is still stored.
- R5: A falling edge on `rxIn` starts a character only if the line is still low half a bit period later. A shorter low pulse stores nothing.
- R6: Every bit is sampled at its centre, timed from the start edge with a period of `bitDiv` cycles (`bitDiv` at least 8). Entries leave the queue in arrival order. `rdValid` is high while the queue is non-empty. `rdData`, `rdParErr` and `rdFrameErr` show the oldest entry, and `rdEn` while `rdValid` pops it. The queue holds DEPTH (480) entries.
- R7: `rtsN` is 0 while the queue holds fewer than WATERMARK (450) entries and 1 while it holds WATERMARK or more.
- R8: A character completed while the queue holds DEPTH entries is discarded and sets `overrun`. The flag stays set until flush or reset.
- R9: `flush` empties the queue and clears `overrun`, taking effect at the next clock edge and overriding a store or a pop in the same cycle.
- R10: `ledOut` is 1 while no character is in progress. While one is in progress, it inverts every ACT_HALF cycles, starting from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial receive line, idle high |
| cfgDataBits | input | 2 | Character length code (R2) |
| cfgParity | input | 3 | Parity mode code (R3) |
| cfgStop | input | 2 | Stop bit code (R4) |
| bitDiv | input | DIV_W | Clock cycles per bit |
| flush | input | 1 | Empty queue, clear overrun |
| rdEn | input | 1 | Pop the oldest entry |
| rdValid | output | 1 | Queue not empty |
| rdData | output | 8 | Oldest data byte |
| rdParErr | output | 1 | Parity error of oldest entry |
| rdFrameErr | output | 1 | Framing error of oldest entry |
| rtsN | output | 1 | Active-low request to send |
| overrun | output | 1 | Sticky discard flag |
| ledOut | output | 1 | Reception activity lamp |

## Verification
The properties assume that `flush` and `rdEn` are synchronous pulses and that the configuration inputs do not change while a character is in progress. The bench changes the format only between characters, after an idle gap of one bit period, and drives every input at the falling clock edge. The properties also assume that `bitDiv` is large enough for the centre samples to clear the input synchronizer delay. The bench uses 16 cycles per bit for the random format mix and 8 cycles per bit for the long fill run.

// File: rtl/serial_rx_wm_pkg.sv
package serial_rx_wm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rxState_t;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_EVEN  = 3'd1;
  localparam logic [2:0] PAR_ODD   = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearShift;
    logic       takeData;
    logic [2:0] bitIdx;
    logic       takePar;
    logic       takeStop;
    logic       commit;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_wm_ctrl.sv
module serial_rx_wm_ctrl
  import serial_rx_wm_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int ACT_HALF = 2400000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic [1:0]       cfgDataBits,
  input  logic [2:0]       cfgParity,
  input  logic [1:0]       cfgStop,
  input  logic [DIV_W-1:0] bitDiv,
  output rxStrobe_t        strobe,
  output logic             rxLevel,
  output logic             ledOut
);
  localparam int ACT_W = (ACT_HALF > 1) ? $clog2(ACT_HALF) : 1;

  rxState_t         state;
  logic             rxMeta, rxSync, rxPrev;
  logic [DIV_W-1:0] baudCnt, limit;
  logic [2:0]       bitCnt, lastBit;
  logic             stopCnt, lastStop;
  logic             tick, startEdge;
  logic [ACT_W-1:0] actCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxLevel   = rxSync;
  assign startEdge = rxPrev && !rxSync;
  assign lastBit   = {1'b0, cfgDataBits} + 3'd4;
  assign lastStop  = (cfgStop == 2'd2);
  assign limit     = (state == ST_START) ? ((bitDiv >> 1) - 1'b1) : (bitDiv - 1'b1);
  assign tick      = (state != ST_IDLE) && (baudCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
      stopCnt <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (startEdge) begin
        state   <= ST_START;
        baudCnt <= '0;
      end
    end else begin
      baudCnt <= tick ? '0 : baudCnt + 1'b1;
      if (tick) begin
        case (state)
          ST_START: begin
            if (!rxSync) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;  // glitch: line back high at mid start bit
            end
          end
          ST_DATA: begin
            if (bitCnt == lastBit) begin
              state   <= (cfgParity == PAR_NONE) ? ST_STOP : ST_PAR;
              stopCnt <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
          ST_PAR: begin
            state   <= ST_STOP;
            stopCnt <= 1'b0;
          end
          ST_STOP: begin
            if (stopCnt == lastStop) state <= ST_IDLE;
            else stopCnt <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clearShift = (state == ST_IDLE) && startEdge;
    strobe.takeData   = tick && (state == ST_DATA);
    strobe.bitIdx     = bitCnt;
    strobe.takePar    = tick && (state == ST_PAR);
    strobe.takeStop   = tick && (state == ST_STOP);
    strobe.commit     = tick && (state == ST_STOP) && (stopCnt == lastStop);
  end

  // activity lamp: high when idle, inverts every ACT_HALF busy cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledOut <= 1'b1;
      actCnt <= '0;
    end else if (state == ST_IDLE) begin
      ledOut <= 1'b1;
      actCnt <= '0;
    end else if (actCnt == ACT_W'(ACT_HALF - 1)) begin
      ledOut <= ~ledOut;
      actCnt <= '0;
    end else begin
      actCnt <= actCnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_wm_dpath.sv
module serial_rx_wm_dpath
  import serial_rx_wm_pkg::*;
#(
  parameter int DEPTH     = 480,
  parameter int WATERMARK = 450
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strobe,
  input  logic       rxLevel,
  input  logic [2:0] cfgParity,
  input  logic       flush,
  input  logic       rdEn,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       rdParErr,
  output logic       rdFrameErr,
  output logic       rtsN,
  output logic       overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       shiftReg;
  logic             parErr, frameErr, expPar, frameNow;
  logic [9:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             full, wrOk, rdOk;

  always_comb begin
    case (cfgParity)
      PAR_EVEN: expPar = ^shiftReg;
      PAR_ODD:  expPar = ~^shiftReg;
      PAR_MARK: expPar = 1'b1;
      default:  expPar = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobe.takeData) shiftReg[strobe.bitIdx] <= rxLevel;
      if (strobe.takePar)  parErr <= (rxLevel != expPar);
      if (strobe.takeStop && !rxLevel) frameErr <= 1'b1;
    end
  end

  assign frameNow = frameErr | (strobe.takeStop & ~rxLevel);
  assign full     = (count == CNT_W'(DEPTH));
  assign wrOk     = strobe.commit && !full;
  assign rdOk     = rdEn && (count != '0);

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= {frameNow, parErr, shiftReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (rdOk) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (wrOk && !rdOk)      count <= count + 1'b1;
      else if (rdOk && !wrOk) count <= count - 1'b1;
      if (strobe.commit && full) overrun <= 1'b1;
    end
  end

  assign rdValid    = (count != '0);
  assign rdData     = mem[rdPtr][7:0];
  assign rdParErr   = mem[rdPtr][8];
  assign rdFrameErr = mem[rdPtr][9];
  assign rtsN       = (count >= CNT_W'(WATERMARK));
endmodule

// File: rtl/serial_rx_wm.sv
module serial_rx_wm
  import serial_rx_wm_pkg::*;
#(
  parameter int DEPTH     = 480,
  parameter int WATERMARK = 450,
  parameter int DIV_W     = 16,
  parameter int ACT_HALF  = 2400000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic [1:0]       cfgDataBits,
  input  logic [2:0]       cfgParity,
  input  logic [1:0]       cfgStop,
  input  logic [DIV_W-1:0] bitDiv,
  input  logic             flush,
  input  logic             rdEn,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             rdParErr,
  output logic             rdFrameErr,
  output logic             rtsN,
  output logic             overrun,
  output logic             ledOut
);
  rxStrobe_t strobe;
  logic      rxLevel;

  serial_rx_wm_ctrl #(.DIV_W(DIV_W), .ACT_HALF(ACT_HALF)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgDataBits(cfgDataBits),
    .cfgParity(cfgParity), .cfgStop(cfgStop), .bitDiv(bitDiv),
    .strobe(strobe), .rxLevel(rxLevel), .ledOut(ledOut)
  );

  serial_rx_wm_dpath #(.DEPTH(DEPTH), .WATERMARK(WATERMARK)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLevel(rxLevel),
    .cfgParity(cfgParity), .flush(flush), .rdEn(rdEn), .rdValid(rdValid),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrameErr(rdFrameErr),
    .rtsN(rtsN), .overrun(overrun)
  );
endmodule

// File: rtl/serial_rx_wm_chk.sv
module serial_rx_wm_chk (
  input logic clk,
  input logic rstN,
  input logic flush,
  input logic rdEn,
  input logic rdValid,
  input logic rtsN,
  input logic overrun
);
  // R9: a flush leaves an empty queue and a cleared overrun flag
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!rdValid && !overrun && !rtsN));

  // R8: overrun holds until flush
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !flush) |=> overrun);

  // R8: overrun can only rise while the queue was past the watermark (full)
  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rtsN));

  // R7: throttling implies stored data
  p_rts_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    rtsN |-> rdValid);

  // R7: throttling is released only by draining or flushing
  p_rts_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtsN) |-> $past(rdEn || flush));
endmodule

bind serial_rx_wm serial_rx_wm_chk chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .rdEn(rdEn),
  .rdValid(rdValid), .rtsN(rtsN), .overrun(overrun)
);

// File: tb/serial_rx_wm_tb.sv
module serial_rx_wm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 480;
  localparam int WATERMARK  = 450;
  localparam int ACT_HALF   = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic [1:0]  cfgDataBits = 2'd3;
  logic [2:0]  cfgParity = 3'd0;
  logic [1:0]  cfgStop = 2'd0;
  logic [15:0] bitDiv = 16'd16;
  logic        flush = 1'b0;
  logic        rdEn = 1'b0;
  logic        rdValid, rdParErr, rdFrameErr, rtsN, overrun, ledOut;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_wm #(.DEPTH(DEPTH), .WATERMARK(WATERMARK), .DIV_W(16), .ACT_HALF(ACT_HALF)) dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgDataBits(cfgDataBits),
    .cfgParity(cfgParity), .cfgStop(cfgStop), .bitDiv(bitDiv), .flush(flush),
    .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrameErr(rdFrameErr), .rtsN(rtsN), .overrun(overrun), .ledOut(ledOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic parBit(input logic [7:0] d, input int par);
    case (par)
      1: return ^d;
      2: return ~^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic hold(input logic v, input int cycles);
    rxIn = v;
    repeat (cycles) @(negedge clk);
  endtask

  // one character, then one idle bit period
  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit badStop,
                           input bit badStop2);
    int nb, div;
    logic [7:0] m;
    nb = 5 + int'(cfgDataBits);
    div = int'(bitDiv);
    m = d & ((8'd1 << nb) - 8'd1);
    hold(1'b0, div);
    for (int i = 0; i < nb; i++) hold(m[i], div);
    if (cfgParity != 3'd0) hold(parBit(m, int'(cfgParity)) ^ badPar, div);
    hold(!badStop, div);
    if (cfgStop == 2'd1) hold(1'b1, div / 2);
    if (cfgStop == 2'd2) hold(!badStop2, div);
    hold(1'b1, div);
  endtask

  task automatic popCheck(input string req, input logic [7:0] d, input logic pe, input logic fe);
    check(rdValid == 1'b1, {req, " valid"}, rdValid, 1);
    check(rdData == d, {req, " data"}, rdData, d);
    check(rdParErr == pe, {req, " parity flag"}, rdParErr, pe);
    check(rdFrameErr == fe, {req, " frame flag"}, rdFrameErr, fe);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCfg(input int nb, input int par, input int stp);
    cfgDataBits = 2'(nb - 5);
    cfgParity = 3'(par);
    cfgStop = 2'(stp);
  endtask

  task automatic pulseFlush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdValid == 0, "R1 rdValid", rdValid, 0);
    check(rtsN == 0, "R1 rtsN", rtsN, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
    check(ledOut == 1, "R1 ledOut", ledOut, 1);

    // R2 directed: 5 bits, upper bits dropped; 2 stop bits
    setCfg(5, 0, 2);
    sendFrame(8'hFF, 0, 0, 0);
    popCheck("R2 5-bit", 8'h1F, 0, 0);
    setCfg(8, 0, 0);
    sendFrame(8'hA5, 0, 0, 0);
    popCheck("R2 8-bit", 8'hA5, 0, 0);

    // R3 directed: even parity corrupted, mark parity good
    setCfg(8, 1, 0);
    sendFrame(8'h37, 1, 0, 0);
    popCheck("R3 even bad", 8'h37, 1, 0);
    setCfg(7, 3, 0);
    sendFrame(8'h55, 0, 0, 0);
    popCheck("R3 mark good", 8'h55, 0, 0);

    // R4 directed: second of two stop bits low; 1.5 stop good
    setCfg(6, 2, 2);
    sendFrame(8'h2A, 0, 0, 1);
    popCheck("R4 second stop low", 8'h2A, 0, 1);
    setCfg(5, 4, 1);
    sendFrame(8'h13, 0, 1, 0);
    popCheck("R4 first stop low", 8'h13, 0, 1);

    // R5 glitch shorter than half a bit
    hold(1'b0, 3);
    hold(1'b1, 48);
    check(rdValid == 0, "R5 glitch stored nothing", rdValid, 0);

    // R10 lamp during a character, then idle
    setCfg(8, 0, 0);
    fork
      sendFrame(8'h81, 0, 0, 0);
      begin
        repeat (60) @(negedge clk);
        check(ledOut == 0, "R10 lamp toggled while busy", ledOut, 0);
      end
    join
    check(ledOut == 1, "R10 lamp high when idle", ledOut, 1);
    popCheck("R10 byte", 8'h81, 0, 0);

    // R2 R3 R4 R6 random formats
    for (int k = 0; k < 40; k++) begin
      int nb, par, stp;
      logic [7:0] d, m;
      bit bp, bs, bs2;
      nb = 5 + int'($urandom % 4);
      par = int'($urandom % 5);
      stp = int'($urandom % 3);
      d = 8'($urandom);
      bp = (par != 0) && ($urandom % 6 == 0);
      bs = ($urandom % 8 == 0);
      bs2 = (stp == 2) && ($urandom % 8 == 0);
      setCfg(nb, par, stp);
      sendFrame(d, bp, bs, bs2);
      m = d & ((8'd1 << nb) - 8'd1);
      popCheck("R2 R3 R4 R6 random", m, bp, bs | bs2);
    end

    // R7 R8 fill the queue at 8 cycles per bit
    bitDiv = 16'd8;
    setCfg(8, 0, 0);
    for (int i = 0; i < WATERMARK - 1; i++) sendFrame(8'(i), 0, 0, 0);
    check(rtsN == 0, "R7 below watermark", rtsN, 0);
    sendFrame(8'(WATERMARK - 1), 0, 0, 0);
    check(rtsN == 1, "R7 at watermark", rtsN, 1);
    for (int i = WATERMARK; i < DEPTH; i++) sendFrame(8'(i), 0, 0, 0);
    check(overrun == 0, "R8 full without overrun", overrun, 0);
    sendFrame(8'hEE, 0, 0, 0);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - WATERMARK) check(rtsN == 1, "R7 still at watermark", rtsN, 1);
      if (i == DEPTH - WATERMARK + 1) check(rtsN == 0, "R7 released", rtsN, 0);
      popCheck("R6 fifo order", 8'(i), 0, 0);
    end
    check(rdValid == 0, "R8 dropped byte absent", rdValid, 0);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // R9 flush
    for (int i = 0; i < 3; i++) sendFrame(8'(8'h60 + i), 0, 0, 0);
    check(rdValid == 1, "R9 data before flush", rdValid, 1);
    pulseFlush();
    check(rdValid == 0, "R9 flush empties", rdValid, 0);
    check(overrun == 0, "R9 flush clears overrun", overrun, 0);
    sendFrame(8'h3C, 0, 0, 0);
    popCheck("R9 after flush", 8'h3C, 0, 0);

    finishRun();
  end
endmodule